// File: doc/BRIEF.md
# Clocked Non-Retriggerable One-Shot with Clear

This block turns trigger activity on three asynchronous control lines into one output pulse whose length is a count of clock cycles. It drives a true output and its complement. A pulse can start in three ways:

- a falling edge on the active-low trigger, while the active-high trigger and clear are both high;
- a rising edge on the active-high trigger, while the active-low trigger is low and clear is high;
- the release of clear, while the two triggers already sit in their active levels.

Once a pulse is running it cannot be extended or restarted. Holding clear low cuts it short.

All three control lines are synchronized to the block clock, and edges are found on the synchronized copies. The pulse length is sampled from a width input at the moment of triggering. A width of zero means no pulse.

Top module: `oneshot_pulse`

## Requirements
- R1: While reset is asserted and after its release, q_o is low and qn_o is high. qn_o equals the inverse of q_o at every sampled cycle.
- R2: A falling edge on a_ni with b_i high and clr_ni high starts a pulse. q_o rises on the third rising clock edge after the input change and stays high for exactly width_i cycles.
- R3: A falling edge on a_ni while b_i is low, or while clr_ni is low, produces no pulse.
- R4: A rising edge on b_i with a_ni low and clr_ni high starts a pulse of width_i cycles. A rising edge on b_i while a_ni is high produces no pulse.
- R5: While q_o is high, further edges on a_ni and b_i neither lengthen, shorten nor restart the pulse.
- R6: width_i is captured when the pulse starts. Changing it during the pulse leaves that pulse's length unchanged.
- R7: A width of zero at the moment of triggering produces no pulse. q_o stays low.
- R8: clr_ni held low ends an active pulse. q_o falls on the third rising edge after clr_ni goes low, whatever count remains.
- R9: A low-to-high transition on clr_ni starts a pulse of width_i cycles when b_i is already high and a_ni is low. Raising b_i while clr_ni is low starts nothing.
- R10: A trigger edge whose synchronized form arrives during the last active cycle of a pulse is ignored. The same edge one cycle later starts a new pulse after exactly one low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_ni | input | 1 | Trigger, active on a falling edge (asynchronous) |
| b_i | input | 1 | Trigger, active on a rising edge (asynchronous) |
| clr_ni | input | 1 | Clear, active low. Its rising edge can also trigger (asynchronous) |
| width_i | input | WIDTH_W | Pulse length in clock cycles, sampled at trigger |
| q_o | output | 1 | Pulse output, high during the pulse |
| qn_o | output | 1 | Complement of q_o |

## Verification
The hardest situation to reach is a trigger edge that lands exactly on the final active cycle of a pulse, together with its neighbour one cycle later. The stimulus reaches it by counting falling clock edges from the first trigger. It then places a second falling edge on a_ni either W or W+1 half-periods-aligned cycles later. The two-stage synchronizer delay puts the edge seen inside the block on the last active cycle in the first case and on the first idle cycle in the second. The scoreboard then expects one pulse in the first case, and two pulses with a single low cycle between them in the second.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic a;    // active-low trigger
    logic b;    // active-high trigger
    logic clr;  // active-low clear
  } trig_in_t;

  // idle history: a high, b low, clear high
  localparam trig_in_t TRIG_IDLE = '{a: 1'b1, b: 1'b0, clr: 1'b1};
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {STAGES{RST_VAL[i]}};
      else         ff_q <= {ff_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/os_trig_detect.sv
module os_trig_detect
  import oneshot_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  trig_in_t cur_i,
  output logic     fire_o
);
  trig_in_t prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= TRIG_IDLE;
    else         prev_q <= cur_i;
  end

  logic a_fall, b_rise, clr_rise, armed;
  assign a_fall   = prev_q.a & ~cur_i.a;
  assign b_rise   = ~prev_q.b & cur_i.b;
  assign clr_rise = ~prev_q.clr & cur_i.clr;
  assign armed    = cur_i.clr & cur_i.b & ~cur_i.a;

  assign fire_o = armed & (a_fall | b_rise | clr_rise);
endmodule

// File: rtl/os_width_ctr.sv
module os_width_ctr #(
  parameter int unsigned WIDTH_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_n_i,
  input  logic               fire_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               active_o,
  output logic [WIDTH_W-1:0] cnt_o
);
  localparam logic [WIDTH_W-1:0] ONE = WIDTH_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
    end else if (!clr_n_i) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
    end else if (active_o) begin
      cnt_o <= cnt_o - ONE;
      if (cnt_o == ONE) active_o <= 1'b0;
    end else if (fire_i && width_i != '0) begin
      active_o <= 1'b1;
      cnt_o    <= width_i;
    end
  end
endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               a_ni,
  input  logic               b_i,
  input  logic               clr_ni,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               q_o,
  output logic               qn_o
);
  trig_in_t raw, syn;
  logic fire, active;
  logic [WIDTH_W-1:0] cnt;

  assign raw = '{a: a_ni, b: b_i, clr: clr_ni};

  os_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(TRIG_IDLE)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  os_trig_detect u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(syn), .fire_o(fire)
  );

  os_width_ctr #(.WIDTH_W(WIDTH_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_n_i(syn.clr), .fire_i(fire),
    .width_i(width_i), .active_o(active), .cnt_o(cnt)
  );

  assign q_o  = active;
  assign qn_o = ~active;
endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
  parameter int unsigned WIDTH_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               q_o,
  input logic               qn_o,
  input logic               clr_s,
  input logic               fire,
  input logic [WIDTH_W-1:0] cnt
);
  localparam logic [WIDTH_W-1:0] ONE = WIDTH_W'(1);

  a_r1_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qn_o == ~q_o);

  a_r2_start_needs_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(fire));

  a_r5_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && clr_s && cnt > ONE) |=> (q_o && cnt == $past(cnt) - ONE));

  a_r8_clear_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_s |=> !q_o);

  a_r10_last_cycle_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && cnt == ONE) |=> !q_o);
endmodule

bind oneshot_pulse oneshot_pulse_chk #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .q_o(q_o), .qn_o(qn_o),
  .clr_s(syn.clr), .fire(fire), .cnt(cnt)
);

// File: tb/oneshot_pulse_test.sv
module oneshot_pulse_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WW = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic a_ni = 1'b1, b_i = 1'b0, clr_ni = 1'b1;
  logic [WW-1:0] width_i = '0;
  logic q_o, qn_o;

  int checks = 0, errors = 0;
  int exp_q[$];
  string exp_tag[$];
  int run_len = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_pulse #(.WIDTH_W(WW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .a_ni(a_ni), .b_i(b_i), .clr_ni(clr_ni),
    .width_i(width_i), .q_o(q_o), .qn_o(qn_o)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(int len, string tag);
    exp_q.push_back(len);
    exp_tag.push_back(tag);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(string tag);
    cyc(12);
    check(exp_q.size() == 0 && q_o == 1'b0, tag, exp_q.size(), 0);
  endtask

  // monitor: measures each pulse and compares against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (qn_o !== ~q_o) check(1'b0, "R1 complement", qn_o, ~q_o);
      if (q_o) run_len++;
      else if (run_len != 0) begin
        if (exp_q.size() == 0) check(1'b0, "unexpected pulse", run_len, 0);
        else begin
          automatic int e = exp_q.pop_front();
          automatic string t = exp_tag.pop_front();
          check(run_len == e, t, run_len, e);
        end
        run_len = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check(q_o == 1'b0 && qn_o == 1'b1, "R1 reset", q_o, 0);
    rst_ni = 1'b1;
    cyc(4);
    check(q_o == 1'b0 && qn_o == 1'b1, "R1 after reset", q_o, 0);

    // R2: a falls with b and clear high
    width_i = 5; b_i = 1; cyc(6);
    push(5, "R2 a-fall pulse"); a_ni = 0;
    cyc(20); a_ni = 1; b_i = 0;
    settle("R2 settle");

    // R3: a falls with b low; then with clear low
    a_ni = 0; cyc(8); a_ni = 1; cyc(4);
    b_i = 1; clr_ni = 0; cyc(4); a_ni = 0; cyc(8); a_ni = 1; cyc(4);
    clr_ni = 1; cyc(4); b_i = 0;
    settle("R3 gated a-fall");

    // R4: b rises with a low; then with a high
    width_i = 7; a_ni = 0; cyc(4);
    push(7, "R4 b-rise pulse"); b_i = 1;
    cyc(20); a_ni = 1; cyc(4); b_i = 0; cyc(4);
    b_i = 1; cyc(8); b_i = 0;
    settle("R4 gated b-rise");

    // R5: toggles during the pulse change nothing
    width_i = 20; b_i = 1; cyc(4);
    push(20, "R5 no retrigger"); a_ni = 0; cyc(4);
    for (int i = 0; i < 3; i++) begin
      a_ni = 1; cyc(1); a_ni = 0; cyc(1); b_i = 0; cyc(1); b_i = 1; cyc(1);
    end
    a_ni = 1; b_i = 0;
    settle("R5 settle");

    // R6: width change mid-pulse
    width_i = 10; b_i = 1; cyc(4);
    push(10, "R6 width sampled"); a_ni = 0; cyc(5);
    width_i = 3; cyc(25); a_ni = 1; b_i = 0;
    settle("R6 settle");

    // R7: zero width
    width_i = 0; b_i = 1; cyc(4); a_ni = 0; cyc(20); a_ni = 1; b_i = 0;
    settle("R7 zero width");

    // R8: clear cuts the pulse: m=4 negedges into it -> 6 cycles high
    width_i = 30; b_i = 1; cyc(4);
    push(6, "R8 clear ends pulse"); a_ni = 0;
    cyc(6); clr_ni = 0; cyc(6);
    check(q_o == 1'b0, "R8 q low under clear", q_o, 0);
    a_ni = 1; cyc(2); clr_ni = 1; cyc(2); b_i = 0;
    settle("R8 settle");

    // R9: b raised under clear, then clear released
    width_i = 4; clr_ni = 0; a_ni = 0; cyc(3); b_i = 1; cyc(8);
    check(q_o == 1'b0, "R9 no pulse under clear", q_o, 0);
    push(4, "R9 clear-rise pulse"); clr_ni = 1;
    cyc(20); a_ni = 1; cyc(2); b_i = 0;
    settle("R9 settle");

    // R10: second a fall lands on last active cycle -> ignored
    width_i = 6; b_i = 1; cyc(4);
    push(6, "R10 last-cycle ignore"); a_ni = 0;
    cyc(2); a_ni = 1; cyc(4); a_ni = 0;
    cyc(20); a_ni = 1; b_i = 0;
    settle("R10 ignore settle");

    // R10: one cycle later -> back-to-back pulse after one low cycle
    b_i = 1; cyc(4);
    push(6, "R10 first pulse"); push(6, "R10 back-to-back");
    a_ni = 0; cyc(2); a_ni = 1; cyc(5); a_ni = 0;
    cyc(25); a_ni = 1; b_i = 0;
    settle("R10 back-to-back settle");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule